// File: doc/BRIEF.md
# Two-Wire Register-Bank Slave

This block is a two-wire (I2C/SMBus style) target that lets a bus master reach a bank of up to 256 byte-wide registers through an internal 8-bit pointer. It resynchronises SCL and SDA to the system clock. It recognises START and STOP conditions, compares the first byte of each transfer against its fixed 7-bit device address, and then handles the transfer. A pointer-only transfer loads the pointer. A write transfer loads the pointer and then stores one or more data bytes at consecutive locations. A read transfer streams bytes out from the current pointer.

The register storage sits outside the block. The block presents the pointer as the bank address, pulses a write strobe with the data byte, and reads `reg_rdata` for the location the pointer selects. A 256-bit mask marks which locations exist. A command byte or write target outside that mask is refused with a NACK. While `reboot` is high the block refuses its own address. SDA is open-drain: `sda_oe` high pulls the line low.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset `sda_oe` is 0, `reg_addr` is 0x00 and `reg_wr_en` is 0.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged by pulling SDA low during the 9th SCL period. Any other address gets no acknowledge, and every later byte of that transfer is ignored: no acknowledge, no write, no pointer change.
- R3: While `reboot` is 1, the block answers its own address with a NACK and ignores the rest of the transfer. Once `reboot` is 0 it acknowledges its address again.
- R4: A transfer of address (R/W bit 0), one valid pointer byte and then STOP acknowledges both bytes, sets `reg_addr` to the pointer byte and writes nothing. STOP never changes `reg_addr`.
- R5: A pointer byte whose bit in `addr_ok` is 0 gets a NACK and leaves `reg_addr` unchanged. The data bytes that follow are ignored.
- R6: A data byte received at a valid pointer is acknowledged and stored. `reg_wr_en` pulses for exactly one clock, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R7: After each stored byte the pointer increments by one, so that successive data bytes land at consecutive locations. The pointer does not move in the clock after the write strobe.
- R8: A data byte that arrives while the pointer selects an invalid location gets a NACK, is not stored and does not advance the pointer.
- R9: An address byte with the R/W bit 1 is acknowledged. Bytes are then sent MSB first from the current pointer, SDA is released for the master's acknowledge bit, and the pointer increments after every byte sent.
- R10: After the master answers a read byte with a NACK, the block keeps SDA released until the next START or STOP.
- R11: A START at any point aborts the transfer in progress, discards a partly received byte and begins a new address phase.
- R12: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 8 | Register pointer, used as bank address |
| reg_wr_en | output | 1 | One-clock write strobe |
| reg_wdata | output | 8 | Byte to store |
| reg_rdata | input | 8 | Bank content at `reg_addr` |
| addr_ok | input | 256 | Bit n set when location n exists |
| reboot | input | 1 | 1 while the device is restarting |

## Verification
The bench builds the block with its default device address 0x52 and two synchroniser stages. It runs SCL at a quarter period of ten system clocks, which leaves room for the synchroniser and state delay inside each SCL phase. The valid-location mask is two separate windows, 0x00–0x0F and 0x20–0x22. With this mask, a write burst can run past the end of a window, and reads can cross locations with distinct contents. A foreign address, an out-of-window pointer, a reboot period and an abort in the middle of a byte each end in a transfer the bench can tell apart from a good one, by the acknowledge bits and by the bank contents.

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h52,
  parameter int         SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_i,
  input  logic         sda_i,
  output logic         sda_oe,
  output logic [7:0]   reg_addr,
  output logic         reg_wr_en,
  output logic [7:0]   reg_wdata,
  input  logic [7:0]   reg_rdata,
  input  logic [255:0] addr_ok,
  input  logic         reboot
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK1, S_ACK2, S_TX, S_MACK, S_WAIT} st_t;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} kind_t;

  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;
  st_t   st;
  kind_t kind;
  logic [2:0] cnt;
  logic [7:0] sh, ptr, rx_byte;
  logic ack_ok, rd_mode, mack, inc_pend;

  assign scl_s     = scl_sr[SYNC_STAGES-1];
  assign sda_s     = sda_sr[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign rx_byte   = {sh[6:0], sda_s};
  assign reg_addr  = ptr;
  assign sda_oe    = (st == S_ACK2 && ack_ok) || (st == S_TX && !sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind      <= K_ADDR;
      cnt       <= '0;
      sh        <= '0;
      ptr       <= '0;
      ack_ok    <= 1'b0;
      rd_mode   <= 1'b0;
      mack      <= 1'b0;
      inc_pend  <= 1'b0;
      reg_wr_en <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      if (start_det) begin
        st   <= S_RX;
        kind <= K_ADDR;
        cnt  <= '0;
      end else if (stop_det) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            sh  <= rx_byte;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              st       <= S_ACK1;
              ack_ok   <= 1'b0;
              inc_pend <= 1'b0;
              case (kind)
                K_ADDR: begin
                  if (rx_byte[7:1] != DEV_ADDR) st <= S_WAIT;
                  else begin
                    ack_ok  <= !reboot;
                    rd_mode <= rx_byte[0];
                  end
                end
                K_CMD: if (addr_ok[rx_byte]) begin
                  ack_ok <= 1'b1;
                  ptr    <= rx_byte;
                end
                default: if (addr_ok[ptr]) begin
                  ack_ok    <= 1'b1;
                  reg_wr_en <= 1'b1;
                  reg_wdata <= rx_byte;
                  inc_pend  <= 1'b1;
                end
              endcase
            end
          end
          S_ACK1: if (scl_fall) st <= S_ACK2;
          S_ACK2: if (scl_fall) begin
            cnt <= '0;
            if (inc_pend) ptr <= ptr + 8'd1;
            if (!ack_ok) st <= S_WAIT;
            else if (kind == K_ADDR && rd_mode) begin
              sh <= reg_rdata;
              st <= S_TX;
            end else begin
              st   <= S_RX;
              kind <= (kind == K_ADDR) ? K_CMD : K_DATA;
            end
          end
          S_TX: if (scl_fall) begin
            sh  <= {sh[6:0], 1'b1};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) st <= S_MACK;
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= !sda_s;
              ptr  <= ptr + 8'd1;
            end else if (scl_fall) begin
              if (mack) begin
                sh  <= reg_rdata;
                cnt <= '0;
                st  <= S_TX;
              end else st <= S_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module i2c_regbank_slave_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_q,
  input logic         stop_det,
  input logic         sda_oe,
  input logic [7:0]   reg_addr,
  input logic         reg_wr_en,
  input logic [255:0] addr_ok
);

  p_oe_moves_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q);

  p_wr_valid_loc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> addr_ok[reg_addr]);

  p_wr_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  p_stop_keeps_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> $stable(reg_addr));

  p_ptr_holds_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> $stable(reg_addr));

endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .stop_det(stop_det),
  .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .addr_ok(addr_ok)
);

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;
  localparam logic [6:0] DEV = 7'h52;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, reboot = 1'b0;
  logic sda_oe, reg_wr_en;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [255:0] addr_ok;
  logic [7:0] mem [256];
  int checks = 0, errors = 0, wr_count = 0;
  wire sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_regbank_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .addr_ok(addr_ok), .reboot(reboot)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_wr_en) begin
    mem[reg_addr] <= reg_wdata;
    wr_count <= wr_count + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; hq(); scl = 1'b1; hq(); m_sda = 1'b0; hq(); scl = 1'b0; hq();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; hq(); scl = 1'b1; hq(); m_sda = 1'b1; hq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0; hq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; hq(); scl = 1'b1; hq();
    ack = !sda_line;
    hq(); scl = 1'b0; hq();
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d, output logic steady);
    logic a, b;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hq(); scl = 1'b1; hq();
      a = sda_line; hq(); b = sda_line;
      if (a != b) steady = 1'b0;
      d[i] = a;
      scl = 1'b0; hq();
    end
    send_bit(!give_ack);
    m_sda = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 reg_addr", int'(reg_addr), 0);
    chk("R1 reg_wr_en", int'(reg_wr_en), 0);
  endtask

  task automatic t_pointer_only();
    logic ack; int w0 = wr_count;
    m_start();
    wr_byte({DEV, 1'b0}, ack); chk("R2 own address ack", int'(ack), 1);
    wr_byte(8'h05, ack);       chk("R4 pointer ack", int'(ack), 1);
    m_stop();
    chk("R4 pointer loaded", int'(reg_addr), 8'h05);
    chk("R4 nothing stored", wr_count, w0);
  endtask

  task automatic t_foreign_addr();
    logic ack; int w0 = wr_count;
    m_start();
    wr_byte({7'h11, 1'b0}, ack); chk("R2 foreign address nack", int'(ack), 0);
    wr_byte(8'h07, ack);         chk("R2 later byte ignored", int'(ack), 0);
    wr_byte(8'h55, ack);         chk("R2 data ignored", int'(ack), 0);
    m_stop();
    chk("R2 pointer untouched", int'(reg_addr), 8'h05);
    chk("R2 no write", wr_count, w0);
  endtask

  task automatic t_bad_pointer();
    logic ack; int w0 = wr_count;
    m_start();
    wr_byte({DEV, 1'b0}, ack); chk("R5 address ack", int'(ack), 1);
    wr_byte(8'h40, ack);       chk("R5 invalid pointer nack", int'(ack), 0);
    wr_byte(8'h99, ack);       chk("R5 following data ignored", int'(ack), 0);
    m_stop();
    chk("R5 pointer unchanged", int'(reg_addr), 8'h05);
    chk("R5 no write", wr_count, w0);
  endtask

  task automatic t_write_burst();
    logic ack; int w0 = wr_count;
    m_start();
    wr_byte({DEV, 1'b0}, ack); chk("R6 address ack", int'(ack), 1);
    wr_byte(8'h0E, ack);       chk("R6 pointer ack", int'(ack), 1);
    wr_byte(8'hA1, ack);       chk("R6 data ack", int'(ack), 1);
    chk("R6 stored at pointer", int'(mem[8'h0E]), 8'hA1);
    wr_byte(8'hB2, ack);       chk("R7 second data ack", int'(ack), 1);
    chk("R7 stored at next location", int'(mem[8'h0F]), 8'hB2);
    chk("R7 pointer advanced twice", int'(reg_addr), 8'h10);
    wr_byte(8'hC3, ack);       chk("R8 invalid target nack", int'(ack), 0);
    chk("R8 not stored", int'(mem[8'h10]), 0);
    chk("R8 pointer held", int'(reg_addr), 8'h10);
    m_stop();
    chk("R6 exactly two writes", wr_count - w0, 2);
  endtask

  task automatic t_read();
    logic ack, steady; logic [7:0] d;
    m_start();
    wr_byte({DEV, 1'b0}, ack); chk("R9 write address ack", int'(ack), 1);
    wr_byte(8'h20, ack);       chk("R9 pointer ack", int'(ack), 1);
    m_start();
    wr_byte({DEV, 1'b1}, ack); chk("R9 read address ack", int'(ack), 1);
    rd_byte(1'b1, d, steady);
    chk("R9 first byte", int'(d), 8'h3C);
    chk("R12 SDA steady while SCL high", int'(steady), 1);
    rd_byte(1'b0, d, steady);
    chk("R9 second byte", int'(d), 8'hE7);
    rd_byte(1'b0, d, steady);
    chk("R10 released after master nack", int'(d), 8'hFF);
    m_stop();
    chk("R9 pointer after two bytes", int'(reg_addr), 8'h22);
  endtask

  task automatic t_reboot();
    logic ack; int w0 = wr_count;
    reboot = 1'b1;
    m_start();
    wr_byte({DEV, 1'b0}, ack); chk("R3 nack while rebooting", int'(ack), 0);
    wr_byte(8'h01, ack);       chk("R3 byte ignored", int'(ack), 0);
    m_stop();
    reboot = 1'b0;
    chk("R3 pointer unchanged", int'(reg_addr), 8'h22);
    chk("R3 no write", wr_count, w0);
    m_start();
    wr_byte({DEV, 1'b0}, ack); chk("R3 ack after reboot", int'(ack), 1);
    m_stop();
  endtask

  task automatic t_abort();
    logic ack; int w0 = wr_count;
    m_start();
    wr_byte({DEV, 1'b0}, ack); chk("R11 address ack", int'(ack), 1);
    wr_byte(8'h03, ack);       chk("R11 pointer ack", int'(ack), 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    m_start();
    wr_byte({DEV, 1'b0}, ack); chk("R11 new address phase ack", int'(ack), 1);
    wr_byte(8'h04, ack);       chk("R11 new pointer ack", int'(ack), 1);
    wr_byte(8'h77, ack);       chk("R11 data ack", int'(ack), 1);
    m_stop();
    chk("R11 new write landed", int'(mem[8'h04]), 8'h77);
    chk("R11 partial byte discarded", int'(mem[8'h03]), 0);
    chk("R11 one write", wr_count - w0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h20] = 8'h3C;
    mem[8'h21] = 8'hE7;
    mem[8'h22] = 8'h5A;
    addr_ok = '0;
    addr_ok[15:0] = '1;
    addr_ok[34:32] = '1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_pointer_only();
    t_foreign_addr();
    t_bad_pointer();
    t_write_burst();
    t_read();
    t_reboot();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule